// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block sits behind a byte-wide serial receiver and turns its stream of bytes into checked command packets. A frame opens with a fixed 16-bit start word and closes with a fixed 16-bit end word. Between them come a 16-bit payload byte count, a 16-bit command code, the payload bytes, and a 16-bit sum over the command and payload bytes. Every 16-bit field travels low byte first. The block hunts for the start word, collects the frame, and checks the start and end words, the sum, the size limit of its payload buffer, and the payload size that each known command expects.

Each complete frame gets a one-byte answer on a ready/valid byte output: 0x2D (accept) or 0xA5 (reject). An accepted frame also pulses a valid strobe for one cycle. With that strobe come the command code, the byte count, the payload bytes and a flag that marks a command code outside the known set. A later status stage can use that flag to report a command error. Baud detection, the serial line itself and the status reply are handled elsewhere.

Top module: `cmd_frame_rx`

## Requirements
- R1: Frame hunting. The block waits for byte 0xE4 and then byte 0x1B (start word 0x1BE4, low byte first). Any other byte while waiting for 0xE4 is dropped with no reply. A byte other than 0x1B in the second position is dropped with no reply, and the block goes back to waiting for 0xE4.
- R2: After the start word, the fields arrive in this order: byte count, command, payload, sum, end word. Each 16-bit field is taken low byte first. The byte count gives the exact number of payload bytes, and it may be zero, in which case the sum follows the command directly.
- R3: The sum is the total, modulo 2^16, of the two command bytes and all payload bytes. The received sum, reassembled low byte first, must equal it. If it does not, the reply is 0xA5 and no valid strobe is given. A reply byte is always either 0x2D or 0xA5.
- R4: The end word must be 0x1B followed by 0xE4 (0xE41B low byte first). Any other end word gives reply 0xA5 and no valid strobe.
- R5: A byte count above MAX_BYTES (16) is rejected right after its second byte arrives: the reply is 0xA5, and once the reply is taken the block hunts for a new start word. The bytes that follow are treated as hunting input.
- R6: Known commands have a fixed payload size. Commands 0x0300 and 0x0400 take 4 bytes (a sector mask, byte 0 holding sectors 0 to 7). Commands 0x000A, 0x000B, 0x000C and 0x000D take 16 bytes (four 32-bit keys). Commands 0x000E, 0x0010, 0x0020 and 0x0004 take 4 bytes (a branch address). Commands 0x0100, 0x0200, 0x0500, 0x0600, 0x000F and 0x0007 take 0 bytes. A known command with any other byte count gets reply 0xA5.
- R7: A command code outside the R6 set is accepted at any byte count up to MAX_BYTES when the framing and sum are correct. It gets reply 0x2D, and pktUnknown is 1 with the valid strobe. For a known command, pktUnknown is 0.
- R8: For an accepted frame, pktValid is high for exactly one cycle, in the same cycle that txValid first shows 0x2D. pktCmd, pktLen and pktData then hold their values until the next accepted frame. In pktData, payload byte i sits at bits 8i+7:8i and unused bytes are zero.
- R9: A reply is held: txValid stays high and txByte stays unchanged until txReady is seen high. Input bytes that arrive while a reply is pending are ignored. After the handshake, the block hunts for a start word.
- R10: After reset, txValid and pktValid are 0, pktCmd is 0, and the block is hunting for a start word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | An input byte is present this cycle |
| rxByte | input | 8 | Input byte from the serial receiver |
| txReady | input | 1 | The downstream side takes the reply byte |
| txValid | output | 1 | A reply byte is offered |
| txByte | output | 8 | Reply byte, 0x2D accept or 0xA5 reject |
| pktValid | output | 1 | One-cycle strobe for an accepted frame |
| pktCmd | output | 16 | Command code of the last accepted frame |
| pktLen | output | 5 | Payload byte count of the last accepted frame |
| pktData | output | 128 | Payload of the last accepted frame, byte 0 in the low bits |
| pktUnknown | output | 1 | The last accepted command is outside the known set |

## Verification
The assertions check on every cycle that a pending reply holds its byte until the handshake, that a reply is only ever 0x2D or 0xA5, and that the valid strobe is a single-cycle pulse matched by an accept reply. They also check that no accepted frame has a byte count above the buffer size or a sum mismatch. Only the bench scenarios can show the rest: that hunting drops stray bytes, that each known command's size rule is enforced, and that a corrupted sum or end word is rejected. They also show that the outputs keep the last accepted frame across rejected ones, and that bytes sent during a stalled reply are dropped.

// File: rtl/cmd_frame_pkg.sv
package cmd_frame_pkg;

  localparam logic [7:0] SYNC_LO = 8'hE4;
  localparam logic [7:0] SYNC_HI = 8'h1B;
  localparam logic [7:0] END_LO  = 8'h1B;
  localparam logic [7:0] END_HI  = 8'hE4;
  localparam logic [7:0] REPLY_ACCEPT = 8'h2D;
  localparam logic [7:0] REPLY_REJECT = 8'hA5;

  typedef enum logic [3:0] {
    ST_HUNT0, ST_HUNT1, ST_LEN0, ST_LEN1, ST_CMD0, ST_CMD1,
    ST_DATA, ST_SUM0, ST_SUM1, ST_END0, ST_END1, ST_REPLY
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic lenLo;
    logic lenHi;
    logic cmdLo;
    logic cmdHi;
    logic data;
    logic sumLo;
    logic sumHi;
    logic endLo;
    logic commit;
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic lenOver;
    logic lenZero;
    logic dataLast;
    logic frameGood;
  } dpSts_t;

  typedef struct packed {
    logic       known;
    logic [7:0] expLen;
  } cmdInfo_t;

  function automatic cmdInfo_t cmdInfo(input logic [15:0] code);
    cmdInfo_t r;
    r.known  = 1'b1;
    r.expLen = 8'd0;
    case (code)
      16'h0300, 16'h0400:                     r.expLen = 8'd4;
      16'h000A, 16'h000B, 16'h000C, 16'h000D: r.expLen = 8'd16;
      16'h000E, 16'h0010, 16'h0020, 16'h0004: r.expLen = 8'd4;
      16'h0100, 16'h0200, 16'h0500, 16'h0600,
      16'h000F, 16'h0007:                     r.expLen = 8'd0;
      default:                                r.known  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmd_frame_dp.sv
module cmd_frame_dp
  import cmd_frame_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  localparam int LEN_W = $clog2(MAX_BYTES + 1),
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             rxByte,
  input  dpCtl_t                 ctl,
  output dpSts_t                 sts,
  output logic [15:0]            pktCmd,
  output logic [LEN_W-1:0]       pktLen,
  output logic [MAX_BYTES*8-1:0] pktData,
  output logic                   pktUnknown
);

  logic [15:0]          lenReg;
  logic [15:0]          cmdReg;
  logic [15:0]          sumAcc;
  logic [15:0]          sumRecv;
  logic                 endLoOk;
  logic [IDX_W-1:0]     dataCnt;
  logic [MAX_BYTES*8-1:0] bufData;
  cmdInfo_t             info;
  logic                 lenMatch;
  logic                 sumMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg  <= '0;
      cmdReg  <= '0;
      sumAcc  <= '0;
      sumRecv <= '0;
      endLoOk <= 1'b0;
      dataCnt <= '0;
    end else begin
      if (ctl.clr) begin
        sumAcc  <= '0;
        dataCnt <= '0;
        endLoOk <= 1'b0;
      end
      if (ctl.lenLo) lenReg[7:0]  <= rxByte;
      if (ctl.lenHi) lenReg[15:8] <= rxByte;
      if (ctl.cmdLo) cmdReg[7:0]  <= rxByte;
      if (ctl.cmdHi) cmdReg[15:8] <= rxByte;
      if (ctl.cmdLo || ctl.cmdHi || ctl.data)
        sumAcc <= sumAcc + {8'd0, rxByte};
      if (ctl.data)  dataCnt <= dataCnt + 1'b1;
      if (ctl.sumLo) sumRecv[7:0]  <= rxByte;
      if (ctl.sumHi) sumRecv[15:8] <= rxByte;
      if (ctl.endLo) endLoOk <= (rxByte == END_LO);
    end
  end

  // Payload buffer, one byte lane per slot
  for (genvar g = 0; g < MAX_BYTES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bufData[g*8 +: 8] <= 8'd0;
      else if (ctl.clr)
        bufData[g*8 +: 8] <= 8'd0;
      else if (ctl.data && dataCnt == IDX_W'(g))
        bufData[g*8 +: 8] <= rxByte;
    end
  end

  always_comb begin
    info     = cmdInfo(cmdReg);
    lenMatch = !info.known || (lenReg == {8'd0, info.expLen});
    sumMatch = (sumRecv == sumAcc);
    sts.lenOver   = ({rxByte, lenReg[7:0]} > 16'(MAX_BYTES));
    sts.lenZero   = (lenReg == 16'd0);
    sts.dataLast  = (({1'b0, dataCnt} + 1'b1) == lenReg[IDX_W:0]);
    sts.frameGood = endLoOk && (rxByte == END_HI) && sumMatch && lenMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktCmd     <= '0;
      pktLen     <= '0;
      pktData    <= '0;
      pktUnknown <= 1'b0;
    end else if (ctl.commit) begin
      pktCmd     <= cmdReg;
      pktLen     <= lenReg[LEN_W-1:0];
      pktData    <= bufData;
      pktUnknown <= !info.known;
    end
  end

  // R5: an accepted frame never exceeds the buffer
  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> (lenReg <= 16'(MAX_BYTES)));

  // R3: an accepted frame always carries a matching sum
  assert_sum_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> (sumRecv == sumAcc));

endmodule

// File: rtl/cmd_frame_ctrl.sv
module cmd_frame_ctrl
  import cmd_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReady,
  input  dpSts_t     sts,
  output dpCtl_t     ctl,
  output logic       txValid,
  output logic [7:0] txByte,
  output logic       pktValid
);

  rxState_t state, nextState;
  logic     replyLoad;
  logic     replyAccept;
  logic [7:0] replyReg;
  logic     pulse;

  always_comb begin
    ctl         = '0;
    nextState   = state;
    replyLoad   = 1'b0;
    replyAccept = 1'b0;
    if (state == ST_REPLY) begin
      if (txReady) nextState = ST_HUNT0;
    end else if (rxValid) begin
      case (state)
        ST_HUNT0: if (rxByte == SYNC_LO) begin
          ctl.clr   = 1'b1;
          nextState = ST_HUNT1;
        end
        ST_HUNT1: nextState = (rxByte == SYNC_HI) ? ST_LEN0 : ST_HUNT0;
        ST_LEN0: begin
          ctl.lenLo = 1'b1;
          nextState = ST_LEN1;
        end
        ST_LEN1: begin
          ctl.lenHi = 1'b1;
          if (sts.lenOver) begin
            replyLoad = 1'b1;
            nextState = ST_REPLY;
          end else begin
            nextState = ST_CMD0;
          end
        end
        ST_CMD0: begin
          ctl.cmdLo = 1'b1;
          nextState = ST_CMD1;
        end
        ST_CMD1: begin
          ctl.cmdHi = 1'b1;
          nextState = sts.lenZero ? ST_SUM0 : ST_DATA;
        end
        ST_DATA: begin
          ctl.data = 1'b1;
          if (sts.dataLast) nextState = ST_SUM0;
        end
        ST_SUM0: begin
          ctl.sumLo = 1'b1;
          nextState = ST_SUM1;
        end
        ST_SUM1: begin
          ctl.sumHi = 1'b1;
          nextState = ST_END0;
        end
        ST_END0: begin
          ctl.endLo = 1'b1;
          nextState = ST_END1;
        end
        ST_END1: begin
          replyLoad   = 1'b1;
          replyAccept = sts.frameGood;
          ctl.commit  = sts.frameGood;
          nextState   = ST_REPLY;
        end
        default: nextState = ST_HUNT0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT0;
      replyReg <= REPLY_REJECT;
      pulse    <= 1'b0;
    end else begin
      state <= nextState;
      pulse <= ctl.commit;
      if (replyLoad)
        replyReg <= replyAccept ? REPLY_ACCEPT : REPLY_REJECT;
    end
  end

  assign txValid  = (state == ST_REPLY);
  assign txByte   = replyReg;
  assign pktValid = pulse;

  // R9: a pending reply stays put until taken
  assert_reply_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

  // R3: only the two reply codes ever appear
  assert_reply_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txByte == REPLY_ACCEPT || txByte == REPLY_REJECT));

  // R8: the strobe comes with an accept reply
  assert_strobe_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (txValid && txByte == REPLY_ACCEPT));

  // R8: the strobe lasts one cycle
  assert_strobe_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |=> !pktValid);

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmd_frame_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxValid,
  input  logic [7:0]             rxByte,
  input  logic                   txReady,
  output logic                   txValid,
  output logic [7:0]             txByte,
  output logic                   pktValid,
  output logic [15:0]            pktCmd,
  output logic [LEN_W-1:0]       pktLen,
  output logic [MAX_BYTES*8-1:0] pktData,
  output logic                   pktUnknown
);

  dpCtl_t ctl;
  dpSts_t sts;

  cmd_frame_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .txReady  (txReady),
    .sts      (sts),
    .ctl      (ctl),
    .txValid  (txValid),
    .txByte   (txByte),
    .pktValid (pktValid)
  );

  cmd_frame_dp #(.MAX_BYTES(MAX_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxByte     (rxByte),
    .ctl        (ctl),
    .sts        (sts),
    .pktCmd     (pktCmd),
    .pktLen     (pktLen),
    .pktData    (pktData),
    .pktUnknown (pktUnknown)
  );

endmodule

// File: tb/cmd_frame_rx_bench.sv
module cmd_frame_rx_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rxValid = 1'b0;
  logic [7:0]   rxByte = 8'h00;
  logic         txReady = 1'b1;
  logic         txValid;
  logic [7:0]   txByte;
  logic         pktValid;
  logic [15:0]  pktCmd;
  logic [4:0]   pktLen;
  logic [127:0] pktData;
  logic         pktUnknown;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  logic [15:0]  lastCmd  = 16'h0;
  logic [4:0]   lastLen  = 5'd0;
  logic [127:0] lastData = '0;

  always #5 clk = ~clk;

  cmd_frame_rx u_cmd_frame_rx (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .txReady(txReady), .txValid(txValid), .txByte(txByte),
    .pktValid(pktValid), .pktCmd(pktCmd), .pktLen(pktLen),
    .pktData(pktData), .pktUnknown(pktUnknown)
  );

  // fault: 0 none, 1 corrupt sum, 2 corrupt end word
  typedef struct packed {
    logic [15:0]  cmd;
    logic [4:0]   len;
    logic [127:0] data;
    logic [1:0]   fault;
    logic         expAck;
    logic         expUnk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0300, 5'd4,  128'h0000000F,                         2'd0, 1'b1, 1'b0}, // R6 erase mask
    '{16'h0400, 5'd3,  128'h00112233,                         2'd0, 1'b0, 1'b0}, // R6 wrong size
    '{16'h000A, 5'd16, 128'h0F0E0D0C0B0A09080706050403020100, 2'd0, 1'b1, 1'b0}, // R6 keys
    '{16'h000E, 5'd4,  128'h80001234,                         2'd0, 1'b1, 1'b0}, // R6 branch
    '{16'h0100, 5'd0,  128'h0,                                2'd0, 1'b1, 1'b0}, // R2 empty
    '{16'h0100, 5'd2,  128'hABCD,                             2'd0, 1'b0, 1'b0}, // R6 wrong size
    '{16'h1234, 5'd5,  128'h5544332211,                       2'd0, 1'b1, 1'b1}, // R7 unknown
    '{16'h0300, 5'd4,  128'hDEADBEEF,                         2'd1, 1'b0, 1'b0}, // R3 bad sum
    '{16'h000E, 5'd4,  128'h01020304,                         2'd2, 1'b0, 1'b0}, // R4 bad end
    '{16'h000F, 5'd0,  128'h0,                                2'd0, 1'b1, 1'b0}, // R2 empty
    '{16'hFFFF, 5'd16, {16{8'hFF}},                           2'd0, 1'b1, 1'b1}  // R7 full buffer
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxByte  = b;
  endtask

  task automatic endBytes();
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendFrame(input logic [15:0] cmd, input logic [4:0] len,
                           input logic [127:0] data, input logic [1:0] fault);
    logic [15:0] sum;
    sum = 16'(cmd[7:0]) + 16'(cmd[15:8]);
    for (int i = 0; i < int'(len); i++) sum = sum + 16'(data[i*8 +: 8]);
    if (fault == 2'd1) sum = sum ^ 16'h0001;
    sendByte(8'hE4); sendByte(8'h1B);
    sendByte({3'd0, len}); sendByte(8'h00);
    sendByte(cmd[7:0]); sendByte(cmd[15:8]);
    for (int i = 0; i < int'(len); i++) sendByte(data[i*8 +: 8]);
    sendByte(sum[7:0]); sendByte(sum[15:8]);
    sendByte(8'h1B);
    sendByte((fault == 2'd2) ? 8'h00 : 8'hE4);
    endBytes();
  endtask

  task automatic checkReply(input bit expAck, input string req);
    chk(txValid == 1'b1, req, 128'(txValid), 128'(1));
    chk(txByte == (expAck ? 8'h2D : 8'hA5), req, 128'(txByte), 128'(expAck ? 8'h2D : 8'hA5));
    chk(pktValid == expAck, req, 128'(pktValid), 128'(expAck));
  endtask

  task automatic checkHeld(input string req);
    chk(pktCmd == lastCmd, req, 128'(pktCmd), 128'(lastCmd));
    chk(pktLen == lastLen, req, 128'(pktLen), 128'(lastLen));
    chk(pktData == lastData, req, pktData, lastData);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(txValid == 1'b0, "R10 txValid", 128'(txValid), 128'(0));
    chk(pktValid == 1'b0, "R10 pktValid", 128'(pktValid), 128'(0));
    chk(pktCmd == 16'h0, "R10 pktCmd", 128'(pktCmd), 128'(0));
    rstN = 1'b1;
    @(negedge clk);

    // Table of frames
    for (int v = 0; v < NV; v++) begin
      sendFrame(VECS[v].cmd, VECS[v].len, VECS[v].data, VECS[v].fault);
      checkReply(VECS[v].expAck, "R3 R4 R6 reply");
      if (VECS[v].expAck) begin
        lastCmd  = VECS[v].cmd;
        lastLen  = VECS[v].len;
        lastData = VECS[v].data;
        chk(pktUnknown == VECS[v].expUnk, "R7 unknown flag", 128'(pktUnknown), 128'(VECS[v].expUnk));
      end
      checkHeld("R8 payload out");
      @(negedge clk);
      chk(pktValid == 1'b0, "R8 pulse width", 128'(pktValid), 128'(0));
      chk(txValid == 1'b0, "R9 reply taken", 128'(txValid), 128'(0));
    end

    // R1 hunting: stray bytes draw no reply
    begin
      logic [7:0] junk [5] = '{8'h00, 8'h1B, 8'hE4, 8'h00, 8'h55};
      for (int i = 0; i < 5; i++) begin
        sendByte(junk[i]);
        @(negedge clk);
        rxValid = 1'b0;
        chk(txValid == 1'b0, "R1 no reply to stray byte", 128'(txValid), 128'(0));
      end
    end
    sendFrame(16'h0010, 5'd4, 128'hCAFEF00D, 2'd0);
    checkReply(1'b1, "R1 frame after stray bytes");
    lastCmd = 16'h0010; lastLen = 5'd4; lastData = 128'hCAFEF00D;
    checkHeld("R8 R1 fields");
    @(negedge clk);

    // R5 count too large, low byte
    sendByte(8'hE4); sendByte(8'h1B); sendByte(8'd17); sendByte(8'h00);
    endBytes();
    checkReply(1'b0, "R5 count 17");
    // R5 count too large, high byte
    sendByte(8'hE4); sendByte(8'h1B); sendByte(8'h00); sendByte(8'h01);
    endBytes();
    checkReply(1'b0, "R5 count 256");
    checkHeld("R8 held after R5");
    sendFrame(16'h0004, 5'd4, 128'h11223344, 2'd0);
    checkReply(1'b1, "R5 hunting resumes");
    lastCmd = 16'h0004; lastLen = 5'd4; lastData = 128'h11223344;
    checkHeld("R8 after R5");
    @(negedge clk);

    // R9 stalled reply
    txReady = 1'b0;
    sendFrame(16'h0007, 5'd0, 128'h0, 2'd0);
    checkReply(1'b1, "R9 stalled accept");
    lastCmd = 16'h0007; lastLen = 5'd0; lastData = '0;
    for (int i = 0; i < 3; i++) begin
      sendByte(8'hE4);
      endBytes();
      chk(txValid == 1'b1 && txByte == 8'h2D, "R9 reply held", 128'({txValid, txByte}), 128'({1'b1, 8'h2D}));
      chk(pktValid == 1'b0, "R8 single pulse while stalled", 128'(pktValid), 128'(0));
    end
    txReady = 1'b1;
    @(negedge clk);
    chk(txValid == 1'b0, "R9 released", 128'(txValid), 128'(0));
    sendFrame(16'h000B, 5'd16, 128'h00FF00FF00FF00FF00FF00FF00FF00FF, 2'd0);
    checkReply(1'b1, "R9 bytes during reply ignored");
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule